// File: doc/BRIEF.md
# Write-Lock-Aware FIFO Storage with Bypass

This block is the storage array beneath a receive-data FIFO. It has a write port and a read port, and each port runs on its own clock. The array it models will not accept a write to the location that its read port is addressing at that moment. Pointer generation and empty/full flags sit outside the block.

When the FIFO is empty, the read pointer and the write pointer are equal. A write to that shared location would normally be blocked. To prevent this, the block decides combinationally which address to present to the array's read port. If the write enable is high and the read address matches the write address, it substitutes the write address with its lowest bit inverted. This frees the target location, so the write goes through.

Substituting the address means the registered array output does not match the requested location during that cycle. To cover for this, a bypass register captures every accepted write word. An output multiplexer, driven by an external empty input that is synchronous to the read clock, returns the bypass word in place of the array word.

Top module: `wlock_fifo_store`

## Requirements
- R1: A write with `wr_en` high at a `wr_clk` rising edge stores `wr_data` at `wr_addr`. When `rd_empty` is low, presenting that address on `rd_addr` returns the word on `rd_data` after the next `rd_clk` rising edge.
- R2: The array read is registered. A change of `rd_addr` between `rd_clk` edges leaves `rd_data` unchanged until the next `rd_clk` rising edge.
- R3: A write whose `wr_addr` equals `rd_addr` while `wr_en` is high is still stored at `wr_addr`. The location is readable afterwards.
- R4: In such a colliding write, the internal read address becomes `wr_addr` with bit 0 inverted. The word stored at that neighbour location is left unchanged.
- R5: With `wr_en` low, a `wr_clk` edge changes neither the array contents nor the bypass register.
- R6: The bypass register holds the word of the most recent write with `wr_en` high. While `rd_empty` is 1, `rd_data` shows that word.
- R7: While `rd_empty` is 0, `rd_data` shows the registered array read word.
- R8: After reset (`wr_rst_n` and `rd_rst_n` low, both active-low and synchronous), the bypass register and the array read register are both zero, so `rd_data` is zero whatever the value of `rd_empty`.
- R9: While `wr_en` is high, the address presented to the array's read port never equals `wr_addr`. When there is no collision, it equals `rd_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-port clock |
| wr_rst_n | input | 1 | Synchronous active-low reset, write domain |
| wr_en | input | 1 | Write enable |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_clk | input | 1 | Read-port clock |
| rd_rst_n | input | 1 | Synchronous active-low reset, read domain |
| rd_addr | input | ADDR_W | Read address |
| rd_empty | input | 1 | FIFO empty, selects the bypass word (read domain) |
| rd_data | output | DATA_W | Read data |

## Verification
The bench fills every location of a 16-entry, 8-bit configuration while the read address is parked elsewhere, then reads each location back. A wrong write path or a missing read register would return mismatched words, or words a cycle early.

It then writes every even location with the read address pointing at that same location. If steering were missing, the write would be locked out and the old word would read back. If the steered address were wrong, the wrong location would be locked. The bench also reads each odd neighbour, which catches a write that strays onto the steered address.

The remaining checks confirm three things. A write with enable low must disturb nothing. The bypass word must track the last accepted write. The empty select must choose the correct source.

// File: rtl/wlock_store_pkg.sv
// Package: shared helpers for the write-lock-aware FIFO storage.
// Assumes address widths of at least one bit.
package wlock_store_pkg;

    // Return the address with its least significant bit inverted.
    function automatic logic [31:0] flip_lsb(input logic [31:0] addr);
        return addr ^ 32'd1;
    endfunction

endpackage

// File: rtl/wlock_rd_steer.sv
// Module: wlock_rd_steer
// Picks the address driven into the array read port. When a write targets
// the location being read, it moves the read address to the write address
// with bit 0 inverted, so the locked array accepts the write.
// Assumes: purely combinational; inputs may come from two clock domains.
module wlock_rd_steer
    import wlock_store_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              collide,
    output logic [ADDR_W-1:0] eff_addr
);

    logic [31:0] wide_wr;
    logic [31:0] wide_flip;

    // Zero-extend the write address for the package helper.
    always_comb begin
        wide_wr              = '0;
        wide_wr[ADDR_W-1:0]  = wr_addr;
        wide_flip            = flip_lsb(wide_wr);
    end

    // Detect a collision and choose the effective read address.
    always_comb begin
        collide  = wr_en && (wr_addr == rd_addr);
        eff_addr = collide ? wide_flip[ADDR_W-1:0] : rd_addr;
    end

endmodule

// File: rtl/wlock_array.sv
// Module: wlock_array
// Two-clock storage model. A write is dropped when its address equals the
// address currently on the read port (the lock). The read is registered
// on rd_clk. The storage cells are not reset; the read register is.
// Assumes: lock_addr is the steered read address from wlock_rd_steer.
module wlock_array #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 37
) (
    input  logic              wr_clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic [ADDR_W-1:0] lock_addr,
    output logic [DATA_W-1:0] rd_q
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];
    logic              wr_ok;

    // A write is accepted only when the target is not locked by the read port.
    always_comb begin
        wr_ok = wr_en && (wr_addr != lock_addr);
    end

    // Store an accepted write word.
    always_ff @(posedge wr_clk) begin
        if (wr_ok) begin
            cells[wr_addr] <= wr_data;
        end
    end

    // Register the word at the read-port address.
    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= cells[lock_addr];
        end
    end

endmodule

// File: rtl/wlock_bypass.sv
// Module: wlock_bypass
// Holds the word of the most recent write (enable high) on wr_clk.
// Assumes: the consumer reads it only while the FIFO reports empty.
module wlock_bypass #(
    parameter int DATA_W = 37
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] byp_q
);

    // Capture every enabled write word.
    always_ff @(posedge wr_clk) begin
        if (!wr_rst_n) begin
            byp_q <= '0;
        end else if (wr_en) begin
            byp_q <= wr_data;
        end
    end

endmodule

// File: rtl/wlock_fifo_store.sv
// Module: wlock_fifo_store (top)
// FIFO storage over a write-locked array: read-address steering, the
// array, a bypass register, and an output select driven by rd_empty.
// Assumes: rd_empty is synchronous to rd_clk; pointers are generated outside.
module wlock_fifo_store #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 37
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_empty,
    output logic [DATA_W-1:0] rd_data
);

    logic              collide;
    logic [ADDR_W-1:0] eff_raddr;
    logic [DATA_W-1:0] arr_q;
    logic [DATA_W-1:0] byp_q;

    wlock_rd_steer #(.ADDR_W(ADDR_W)) steer_i (
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .rd_addr  (rd_addr),
        .collide  (collide),
        .eff_addr (eff_raddr)
    );

    wlock_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) array_i (
        .wr_clk    (wr_clk),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_clk    (rd_clk),
        .rd_rst_n  (rd_rst_n),
        .lock_addr (eff_raddr),
        .rd_q      (arr_q)
    );

    wlock_bypass #(.DATA_W(DATA_W)) bypass_i (
        .wr_clk   (wr_clk),
        .wr_rst_n (wr_rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .byp_q    (byp_q)
    );

    // Select the bypass word while empty, the array word otherwise.
    always_comb begin
        rd_data = rd_empty ? byp_q : arr_q;
    end

endmodule

// File: rtl/wlock_fifo_store_chk.sv
// Module: wlock_fifo_store_chk
// Assertion checker bound to wlock_fifo_store.
module wlock_fifo_store_chk #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 37
) (
    input logic              wr_clk,
    input logic              wr_rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [ADDR_W-1:0] eff_raddr,
    input logic [DATA_W-1:0] byp_q
);

    AST_STEER_DIFF: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        wr_en |-> (eff_raddr != wr_addr)); // R9

    AST_NOCOLL_PASS: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (wr_en && (rd_addr != wr_addr)) |-> (eff_raddr == rd_addr)); // R9

    AST_COLL_NEIGHBOUR: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (wr_en && (rd_addr == wr_addr)) |-> ((eff_raddr ^ wr_addr) == ADDR_W'(1))); // R4

    AST_BYPASS_LOAD: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        wr_en |=> (byp_q == $past(wr_data))); // R6

    AST_BYPASS_HOLD: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        !wr_en |=> $stable(byp_q)); // R5

endmodule

bind wlock_fifo_store wlock_fifo_store_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
    .wr_clk    (wr_clk),
    .wr_rst_n  (wr_rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .eff_raddr (eff_raddr),
    .byp_q     (byp_q)
);

// File: tb/wlock_fifo_store_tb_top.sv
// Bench for wlock_fifo_store: 16 locations x 8 bits, exhaustive sweeps.
module wlock_fifo_store_tb_top;

    localparam int AW = 4;
    localparam int DW = 8;
    localparam int N  = 1 << AW;

    logic          wr_clk = 1'b0;
    logic          rd_clk = 1'b0;
    logic          wr_rst_n = 1'b0;
    logic          rd_rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic          rd_empty = 1'b0;
    logic [DW-1:0] rd_data;

    int checks = 0;
    int errors = 0;

    wlock_fifo_store #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
        .wr_clk   (wr_clk),
        .wr_rst_n (wr_rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_clk   (rd_clk),
        .rd_rst_n (rd_rst_n),
        .rd_addr  (rd_addr),
        .rd_empty (rd_empty),
        .rd_data  (rd_data)
    );

    // 100 MHz clocks; the read clock is offset by 2 ns.
    always #5 wr_clk = ~wr_clk;
    initial begin
        #2;
        forever #5 rd_clk = ~rd_clk;
    end

    function automatic logic [DW-1:0] fill_word(input int a);
        return DW'((a * 13 + 7) & 8'hFF);
    endfunction

    function automatic logic [DW-1:0] coll_word(input int a);
        return ~fill_word(a);
    endfunction

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic en, input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge wr_clk);
        wr_en   = en;
        wr_addr = a;
        wr_data = d;
        @(negedge wr_clk);
        wr_en   = 1'b0;
    endtask

    task automatic do_read(input logic [AW-1:0] a, output logic [DW-1:0] q);
        @(negedge rd_clk);
        rd_addr = a;
        @(negedge rd_clk);
        q = rd_data;
    endtask

    initial begin
        #1_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [DW-1:0] q;
        logic [DW-1:0] prev;
        repeat (4) @(negedge wr_clk);
        @(negedge rd_clk);
        rd_empty = 1'b0;
        check("R8 array reg after reset", rd_data, '0);
        rd_empty = 1'b1;
        #1;
        check("R8 bypass after reset", rd_data, '0);
        rd_empty = 1'b0;
        wr_rst_n = 1'b1;
        rd_rst_n = 1'b1;

        // R1: fill every location with the read address parked elsewhere.
        for (int a = 0; a < N; a++) begin
            @(negedge rd_clk);
            rd_addr = AW'(a ^ 8);
            do_write(1'b1, AW'(a), fill_word(a));
        end
        for (int a = 0; a < N; a++) begin
            do_read(AW'(a), q);
            check("R1/R7 fill readback", q, fill_word(a));
        end

        // R2: rd_data holds until the next rd_clk edge.
        do_read(AW'(2), q);
        prev = q;
        @(negedge rd_clk);
        rd_addr = AW'(9);
        #1;
        check("R2 hold before edge", rd_data, prev);
        @(negedge rd_clk);
        check("R2 update after edge", rd_data, fill_word(9));

        // R6: bypass shows the last write.
        rd_empty = 1'b1;
        #1;
        check("R6 bypass last fill", rd_data, fill_word(N - 1));
        rd_empty = 1'b0;

        // R3/R4: colliding writes on even locations.
        for (int a = 0; a < N; a += 2) begin
            @(negedge rd_clk);
            rd_addr = AW'(a);
            do_write(1'b1, AW'(a), coll_word(a));
            rd_empty = 1'b1;
            #1;
            check("R6 bypass after collision", rd_data, coll_word(a));
            rd_empty = 1'b0;
        end
        for (int a = 0; a < N; a += 2) begin
            do_read(AW'(a), q);
            check("R3 collided write stored", q, coll_word(a));
            do_read(AW'(a ^ 1), q);
            check("R4 neighbour untouched", q, fill_word(a ^ 1));
        end

        // R5: write with enable low changes nothing.
        @(negedge rd_clk);
        rd_addr = AW'(0);
        do_write(1'b0, AW'(3), 8'h55);
        do_read(AW'(3), q);
        check("R5 array unchanged", q, fill_word(3));
        rd_empty = 1'b1;
        #1;
        check("R5 bypass unchanged", rd_data, coll_word(N - 2));
        rd_empty = 1'b0;
        #1;
        check("R7 array selected", rd_data, fill_word(3));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule